// File: doc/BRIEF.md
# Video Memory Fill Engine

This block fills a run of video-memory words with one repeated value. The host first programs the command code, the start address, the step size and the run length. A data-port write then arrives while the command's transfer-select field picks fill. That write does not go to memory. Instead the block keeps the written word as the fill value and raises its busy flag. From then on, each clock in which transfers are enabled and the transfer mode selects fill writes the fill value to one memory word. After each such write the address moves forward by the step and the length counts down. Busy drops after the write that consumes the last unit of length.

The same block also carries ordinary host writes into video memory when the command selects a plain memory write. The two write sources share one write port, and the fill engine has priority: while busy, host data-port writes are dropped. The address register, the length register, the command register and the enable bit all live inside the block, and their values are returned on output ports. Busy is also reported as bit 1 of a status word.

Top module: `vram_fill_dma`

## Requirements
- R1: After a synchronous active-low reset, busy is 0 and no write is issued. The address, length, command and enable registers are all 0, and the status word is 0.
- R2: A data-port write while command bits [5:4] equal binary 10 stores the written word as the fill value and sets busy at the next edge. It does not change the address and does not write memory.
- R3: A fill write is issued on a clock only when the enable bit is 1, busy is 1 and the 2-bit transfer mode equals 2. In any other case busy holds and no fill write is issued.
- R4: Every memory write, fill or host, goes to word index address[15:1]. Its data has the two bytes exchanged when address bit 0 is 1 and is unchanged when it is 0.
- R5: After each fill write the address increases by the 8-bit step, modulo 2^16, and the length decreases by 1.
- R6: Busy clears at the edge that ends the fill write issued while the length equals 1, so a programmed length N gives exactly N writes.
- R7: A length of 0 at the start gives 2^LEN_W fill writes, because the count wraps before it is tested.
- R8: The status word carries busy in bit 1, and all its other bits are 0.
- R9: Loading the enable bit with 0 clears command bit 5 at the same edge. This override beats a command load in the same cycle.
- R10: When busy is 0 and command bits [3:0] equal binary 0001, and the command does not select fill, a data-port write is put on the write port in the same cycle. The address then advances by the step and the length is unchanged.
- R11: While busy is 1, a data-port write that is not a fill trigger issues no write and leaves the address unchanged.
- R12: A host load of the address or the length in the same cycle as a fill write takes priority over the step update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| cmdLoad | input | 1 | Load the command register from cmdIn |
| cmdIn | input | 6 | Command code: [5:4] transfer select, [3:0] access kind |
| enLoad | input | 1 | Load the transfer enable bit from enIn |
| enIn | input | 1 | New transfer enable value |
| dmaMode | input | 2 | Transfer mode; 2 selects fill |
| addrLoad | input | 1 | Load the address register |
| addrIn | input | ADDR_W | New address value (byte address) |
| lenLoad | input | 1 | Load the length register |
| lenIn | input | LEN_W | New length value |
| incr | input | INC_W | Address step per write |
| dataWrite | input | 1 | Data-port write strobe |
| dataIn | input | DATA_W | Data-port write value |
| vramWe | output | 1 | Memory write strobe |
| vramAddr | output | ADDR_W-1 | Memory word index |
| vramData | output | DATA_W | Memory write data |
| addrOut | output | ADDR_W | Current address register |
| lenOut | output | LEN_W | Current length register |
| cmdOut | output | 6 | Current command register |
| busy | output | 1 | Fill in progress |
| statusWord | output | 16 | Status word, busy in bit 1 |

## Verification
The bench builds the block with LEN_W set to 8 and keeps the 16-bit address, data and 8-bit step at their defaults. The narrow length makes the zero-length case a run of 256 writes, so the wrap of the count can be watched through to the end. With the step set to 0x80 and a start near the top of the address space, the same run also covers address wraparound. The defaults keep the byte exchange on a true 16-bit word.

// File: rtl/vfill_pkg.sv
package vfill_pkg;

  localparam int CMD_W = 6;

  // transfer-select field value meaning "fill"
  localparam logic [1:0] FILL_SEL    = 2'd2;
  // transfer mode value that lets fill writes run
  localparam logic [1:0] MODE_FILL   = 2'd2;
  // access-kind value for a plain memory write
  localparam logic [3:0] KIND_VRAMWR = 4'd1;

  typedef struct packed {
    logic arm;     // latch fill value, raise busy
    logic step;    // issue one fill write this clock
    logic hostWr;  // pass the data-port write to memory
  } vfillStrobes_t;

endpackage

// File: rtl/vfill_ctrl.sv
module vfill_ctrl
  import vfill_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdLoad,
  input  logic [CMD_W-1:0] cmdIn,
  input  logic             enLoad,
  input  logic             enIn,
  input  logic [1:0]       dmaMode,
  input  logic             dataWrite,
  input  logic             lenOne,
  output vfillStrobes_t    strobes,
  output logic [CMD_W-1:0] cmdOut,
  output logic             dmaOn,
  output logic             busy
);

  logic [CMD_W-1:0] cmdReg;
  logic [CMD_W-1:0] cmdNext;
  logic             enReg;
  logic             activeReg;
  logic             armHit;
  logic             stepHit;
  logic             hostHit;

  always_comb begin
    armHit  = dataWrite && (cmdReg[5:4] == FILL_SEL);
    stepHit = enReg && activeReg && (dmaMode == MODE_FILL);
    hostHit = dataWrite && !armHit && !activeReg && (cmdReg[3:0] == KIND_VRAMWR);
  end

  always_comb begin
    strobes.arm    = armHit;
    strobes.step   = stepHit;
    strobes.hostWr = hostHit;
  end

  // enable cleared by a host load forces the transfer-select high bit low
  always_comb begin
    cmdNext = cmdLoad ? cmdIn : cmdReg;
    if (enLoad && !enIn) cmdNext[5] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= '0;
      enReg  <= 1'b0;
    end else begin
      cmdReg <= cmdNext;
      if (enLoad) enReg <= enIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                activeReg <= 1'b0;
    else if (armHit)          activeReg <= 1'b1;
    else if (stepHit && lenOne) activeReg <= 1'b0;
  end

  assign cmdOut = cmdReg;
  assign dmaOn  = enReg;
  assign busy   = activeReg;

endmodule

// File: rtl/vfill_datapath.sv
module vfill_datapath
  import vfill_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 16,
  parameter int INC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  vfillStrobes_t     strobes,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              lenLoad,
  input  logic [LEN_W-1:0]  lenIn,
  input  logic [INC_W-1:0]  incr,
  input  logic [DATA_W-1:0] dataIn,
  output logic              vramWe,
  output logic [ADDR_W-2:0] vramAddr,
  output logic [DATA_W-1:0] vramData,
  output logic [ADDR_W-1:0] addrOut,
  output logic [LEN_W-1:0]  lenOut,
  output logic              lenOne
);

  localparam int HALF_W = DATA_W / 2;

  logic [ADDR_W-1:0] addrReg;
  logic [LEN_W-1:0]  lenReg;
  logic [DATA_W-1:0] fillReg;
  logic [DATA_W-1:0] srcWord;
  logic [DATA_W-1:0] swapWord;
  logic [ADDR_W-1:0] addrStep;

  always_comb begin
    srcWord  = strobes.step ? fillReg : dataIn;
    swapWord = {srcWord[HALF_W-1:0], srcWord[DATA_W-1:HALF_W]};
    addrStep = addrReg + ADDR_W'(incr);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                               addrReg <= '0;
    else if (addrLoad)                       addrReg <= addrIn;
    else if (strobes.step || strobes.hostWr) addrReg <= addrStep;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             lenReg <= '0;
    else if (lenLoad)      lenReg <= lenIn;
    else if (strobes.step) lenReg <= lenReg - LEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)            fillReg <= '0;
    else if (strobes.arm) fillReg <= dataIn;
  end

  assign vramWe   = strobes.step || strobes.hostWr;
  assign vramAddr = addrReg[ADDR_W-1:1];
  assign vramData = addrReg[0] ? swapWord : srcWord;
  assign addrOut  = addrReg;
  assign lenOut   = lenReg;
  assign lenOne   = (lenReg == LEN_W'(1));

endmodule

// File: rtl/vram_fill_dma.sv
module vram_fill_dma
  import vfill_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int LEN_W    = 16,
  parameter int INC_W    = 8,
  parameter int STAT_W   = 16,
  parameter int BUSY_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdLoad,
  input  logic [5:0]        cmdIn,
  input  logic              enLoad,
  input  logic              enIn,
  input  logic [1:0]        dmaMode,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              lenLoad,
  input  logic [LEN_W-1:0]  lenIn,
  input  logic [INC_W-1:0]  incr,
  input  logic              dataWrite,
  input  logic [DATA_W-1:0] dataIn,
  output logic              vramWe,
  output logic [ADDR_W-2:0] vramAddr,
  output logic [DATA_W-1:0] vramData,
  output logic [ADDR_W-1:0] addrOut,
  output logic [LEN_W-1:0]  lenOut,
  output logic [5:0]        cmdOut,
  output logic              busy,
  output logic [STAT_W-1:0] statusWord
);

  vfillStrobes_t strobes;
  logic          lenOne;
  logic          dmaOn;

  vfill_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdLoad   (cmdLoad),
    .cmdIn     (cmdIn),
    .enLoad    (enLoad),
    .enIn      (enIn),
    .dmaMode   (dmaMode),
    .dataWrite (dataWrite),
    .lenOne    (lenOne),
    .strobes   (strobes),
    .cmdOut    (cmdOut),
    .dmaOn     (dmaOn),
    .busy      (busy)
  );

  vfill_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W),
    .INC_W  (INC_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .addrLoad (addrLoad),
    .addrIn   (addrIn),
    .lenLoad  (lenLoad),
    .lenIn    (lenIn),
    .incr     (incr),
    .dataIn   (dataIn),
    .vramWe   (vramWe),
    .vramAddr (vramAddr),
    .vramData (vramData),
    .addrOut  (addrOut),
    .lenOut   (lenOut),
    .lenOne   (lenOne)
  );

  always_comb begin
    statusWord           = '0;
    statusWord[BUSY_BIT] = busy;
  end

endmodule

// File: rtl/vfill_checker.sv
module vfill_checker #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16,
  parameter int INC_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              dataWrite,
  input logic [5:0]        cmdOut,
  input logic              dmaOn,
  input logic [1:0]        dmaMode,
  input logic              busy,
  input logic              vramWe,
  input logic [ADDR_W-1:0] addrOut,
  input logic [LEN_W-1:0]  lenOut,
  input logic [INC_W-1:0]  incr,
  input logic              addrLoad,
  input logic              lenLoad,
  input logic              enLoad,
  input logic              enIn
);

  a_r2_arm_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    (dataWrite && cmdOut[5:4] == 2'd2) |=> busy);

  a_r3_no_write_when_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(dmaOn && dmaMode == 2'd2)) |-> !vramWe);

  a_r5_addr_advance: assert property (@(posedge clk) disable iff (!rstN)
    (busy && vramWe && !addrLoad) |=> addrOut == $past(addrOut) + ADDR_W'($past(incr)));

  a_r5_len_countdown: assert property (@(posedge clk) disable iff (!rstN)
    (busy && vramWe && !lenLoad) |=> lenOut == $past(lenOut) - LEN_W'(1));

  a_r6_busy_falls_on_last: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(vramWe) && $past(lenOut) == LEN_W'(1)));

  a_r9_enable_clear_cmd5: assert property (@(posedge clk) disable iff (!rstN)
    (enLoad && !enIn) |=> !cmdOut[5]);

  a_r11_host_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (busy && dataWrite && cmdOut[5:4] != 2'd2 && !(dmaOn && dmaMode == 2'd2)) |-> !vramWe);

endmodule

bind vram_fill_dma vfill_checker #(
  .ADDR_W (ADDR_W),
  .LEN_W  (LEN_W),
  .INC_W  (INC_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .dataWrite (dataWrite),
  .cmdOut    (cmdOut),
  .dmaOn     (dmaOn),
  .dmaMode   (dmaMode),
  .busy      (busy),
  .vramWe    (vramWe),
  .addrOut   (addrOut),
  .lenOut    (lenOut),
  .incr      (incr),
  .addrLoad  (addrLoad),
  .lenLoad   (lenLoad),
  .enLoad    (enLoad),
  .enIn      (enIn)
);

// File: tb/vram_fill_dma_tb.sv
module vram_fill_dma_tb;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int LW = 8;
  localparam int IW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN;
  logic          cmdLoad;
  logic [5:0]    cmdIn;
  logic          enLoad;
  logic          enIn;
  logic [1:0]    dmaMode;
  logic          addrLoad;
  logic [AW-1:0] addrIn;
  logic          lenLoad;
  logic [LW-1:0] lenIn;
  logic [IW-1:0] incr;
  logic          dataWrite;
  logic [DW-1:0] dataIn;
  logic          vramWe;
  logic [AW-2:0] vramAddr;
  logic [DW-1:0] vramData;
  logic [AW-1:0] addrOut;
  logic [LW-1:0] lenOut;
  logic [5:0]    cmdOut;
  logic          busy;
  logic [15:0]   statusWord;

  vram_fill_dma #(.LEN_W(LW)) u_dut (
    .clk(clk), .rstN(rstN), .cmdLoad(cmdLoad), .cmdIn(cmdIn),
    .enLoad(enLoad), .enIn(enIn), .dmaMode(dmaMode),
    .addrLoad(addrLoad), .addrIn(addrIn), .lenLoad(lenLoad), .lenIn(lenIn),
    .incr(incr), .dataWrite(dataWrite), .dataIn(dataIn),
    .vramWe(vramWe), .vramAddr(vramAddr), .vramData(vramData),
    .addrOut(addrOut), .lenOut(lenOut), .cmdOut(cmdOut),
    .busy(busy), .statusWord(statusWord)
  );

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  int mCmd, mEn, mAddr, mLen, mFill, mActive;

  function automatic int swapBytes(int w);
    return ((w & 'hFF) << 8) | ((w >> 8) & 'hFF);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick(string tag);
    int doStep, doArm, doHost, doWe, expData;
    #1;
    doStep  = (mEn != 0 && mActive != 0 && int'(dmaMode) == 2) ? 1 : 0;
    doArm   = (dataWrite && ((mCmd >> 4) & 3) == 2) ? 1 : 0;
    doHost  = (dataWrite && doArm == 0 && mActive == 0 && (mCmd & 15) == 1) ? 1 : 0;
    doWe    = (doStep != 0 || doHost != 0) ? 1 : 0;
    check(tag, "vramWe", int'(vramWe), doWe);
    if (doWe != 0) begin
      expData = (doStep != 0) ? mFill : int'(dataIn);
      if ((mAddr & 1) != 0) expData = swapBytes(expData);
      check(tag, "vramAddr", int'(vramAddr), mAddr >> 1);
      check(tag, "vramData", int'(vramData), expData);
    end
    check(tag, "addrOut", int'(addrOut), mAddr);
    check(tag, "lenOut", int'(lenOut), mLen);
    check(tag, "busy", int'(busy), mActive);
    check(tag, "cmdOut", int'(cmdOut), mCmd);
    check("R8", "statusWord", int'(statusWord), (mActive != 0) ? 2 : 0);
    @(posedge clk);
    if (!rstN) begin
      mCmd = 0; mEn = 0; mAddr = 0; mLen = 0; mFill = 0; mActive = 0;
    end else begin
      if (doStep != 0) begin
        mAddr = (mAddr + int'(incr)) & 'hFFFF;
        if (mLen == 1) mActive = 0;
        mLen = (mLen - 1) & 'hFF;
      end
      if (doHost != 0) mAddr = (mAddr + int'(incr)) & 'hFFFF;
      if (doArm != 0) begin
        mFill   = int'(dataIn);
        mActive = 1;
      end
      if (addrLoad) mAddr = int'(addrIn);
      if (lenLoad)  mLen  = int'(lenIn);
      if (cmdLoad)  mCmd  = int'(cmdIn);
      if (enLoad) begin
        mEn = int'(enIn);
        if (!enIn) mCmd = mCmd & ~32;
      end
    end
    @(negedge clk);
    cmdLoad = 0; enLoad = 0; addrLoad = 0; lenLoad = 0; dataWrite = 0;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    mCmd = 0; mEn = 0; mAddr = 0; mLen = 0; mFill = 0; mActive = 0;
    rstN = 0; cmdLoad = 0; cmdIn = '0; enLoad = 0; enIn = 0; dmaMode = 0;
    addrLoad = 0; addrIn = '0; lenLoad = 0; lenIn = '0; incr = '0;
    dataWrite = 0; dataIn = '0;
    @(negedge clk);
    tick("R1");
    tick("R1");
    rstN = 1;
    tick("R1");

    // R10: plain host writes, even and odd address
    cmdLoad = 1; cmdIn = 6'h01; addrLoad = 1; addrIn = 16'h0010; incr = 8'd2;
    tick("R10");
    dataWrite = 1; dataIn = 16'h1234; tick("R10");
    dataWrite = 1; dataIn = 16'h5678; tick("R10");
    addrLoad = 1; addrIn = 16'h0021; tick("R4");
    dataWrite = 1; dataIn = 16'hA1B2; tick("R4");
    tick("R4");

    // R2, R5, R6: arm and run a fill of five words
    cmdLoad = 1; cmdIn = 6'h21; enLoad = 1; enIn = 1; dmaMode = 2'd2;
    addrLoad = 1; addrIn = 16'h0100; lenLoad = 1; lenIn = 8'd5;
    tick("R2");
    dataWrite = 1; dataIn = 16'hABCD; tick("R2");
    for (int i = 0; i < 6; i++) tick("R6");

    // R4: fill from an odd address exchanges bytes
    addrLoad = 1; addrIn = 16'h0301; lenLoad = 1; lenIn = 8'd3; incr = 8'd4;
    tick("R4");
    dataWrite = 1; dataIn = 16'h00FF; tick("R4");
    for (int i = 0; i < 4; i++) tick("R4");

    // R3 and R11: armed but mode not fill, host writes dropped
    dmaMode = 2'd1; lenLoad = 1; lenIn = 8'd4; addrLoad = 1; addrIn = 16'h0200; incr = 8'd1;
    tick("R3");
    dataWrite = 1; dataIn = 16'h1111; tick("R3");
    for (int i = 0; i < 3; i++) tick("R3");
    cmdLoad = 1; cmdIn = 6'h01; tick("R11");
    dataWrite = 1; dataIn = 16'h9999; tick("R11");
    tick("R11");
    dmaMode = 2'd2;
    for (int i = 0; i < 5; i++) tick("R5");

    // R9: enable cleared mid-run stalls and clears command bit 5
    cmdLoad = 1; cmdIn = 6'h21; lenLoad = 1; lenIn = 8'd6; addrLoad = 1; addrIn = 16'h0400;
    tick("R9");
    dataWrite = 1; dataIn = 16'h4242; tick("R9");
    tick("R9");
    tick("R9");
    enLoad = 1; enIn = 0; tick("R9");
    for (int i = 0; i < 3; i++) tick("R9");
    enLoad = 1; enIn = 1; tick("R9");
    for (int i = 0; i < 6; i++) tick("R3");

    // R9: same-cycle command load loses bit 5 to the enable clear
    cmdLoad = 1; cmdIn = 6'h20; enLoad = 1; enIn = 0; tick("R9");
    enLoad = 1; enIn = 1; tick("R9");

    // R12: loads beat the step update
    cmdLoad = 1; cmdIn = 6'h20; lenLoad = 1; lenIn = 8'd4; addrLoad = 1; addrIn = 16'h0500;
    tick("R12");
    dataWrite = 1; dataIn = 16'h7777; tick("R12");
    tick("R12");
    addrLoad = 1; addrIn = 16'h0800; lenLoad = 1; lenIn = 8'd2; tick("R12");
    for (int i = 0; i < 4; i++) tick("R12");

    // R7: zero length runs 2^LEN_W writes, with address wrap
    addrLoad = 1; addrIn = 16'hFF00; incr = 8'h80; lenLoad = 1; lenIn = 8'd0;
    tick("R7");
    dataWrite = 1; dataIn = 16'hC3C3; tick("R7");
    for (int i = 0; i < 258; i++) tick("R7");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule